// File: doc/BRIEF.md
# Dependence Vector Slice Detector

The block watches the stream of committed instructions and keeps a short history of the integer instructions that can feed an address calculation. Stores, branches and floating-point instructions are never recorded. Each recorded entry carries its PC, its instruction word and a dependence bit-vector. That vector has one bit per history slot and marks the entries that produced the instruction's source registers. A per-register producer table builds these vectors at the moment of insertion. When a slot is recycled, its column is cleared from every vector and any table entry that points at it is dropped.

When a commit is flagged as a candidate load, the whole history is copied into a shadow store in a single cycle. A walker then visits one shadow entry per cycle, from the candidate back to the oldest entry, and carries a running dependence vector. An entry whose bit is set in that vector joins the slice and adds its own parent bits to it. The working history keeps accepting commits during the walk. At the end, the slice is written out in one cycle, oldest instruction first and candidate last, tagged with the lead PC, the instruction count and a truncation flag. A downstream slice store can record it under the lead PC.

Top module: `sds_slice_detector`

## Requirements
- R1: While reset is asserted and after its release, `sl_valid` and `busy` are low until a candidate is accepted.
- R2: A commit is recorded only when `cm_kind` is 0 (integer). Kinds 1 (store), 2 (branch) and 3 (floating point) take no history slot and never become a producer.
- R3: The parent of each source is the most recent recorded writer of that register that is still held. Register 0 is never a producer, and a source of register 0 has no parent.
- R4: The history holds at most DEPTH entries. When a commit arrives with the history full, the oldest entry is dropped, and no later slice can contain it.
- R5: Slice membership is transitive. An entry joins when a member that is younger than it names the entry as a parent.
- R6: In `sl_insns`, slot j occupies bits [j*IW +: IW], with slot 0 the oldest member. Slots at or above `sl_count` read zero. `sl_lead_pc` is the PC of slot 0.
- R7: The candidate instruction is always included as the last slot of its slice.
- R8: When the members exceed MAXS, only the MAXS youngest are kept, `sl_count` equals MAXS and `sl_trunc` is 1. Otherwise `sl_trunc` is 0.
- R9: A candidate is accepted at a clock edge where `busy` is low. Call that edge n, and let k be the number of entries held after the candidate is inserted. `busy` is high from edge n until edge n+k. At edge n+k, `sl_valid` rises for exactly one cycle.
- R10: A candidate that commits while `busy` is high is recorded as an ordinary entry but starts no detection. Commits made during a walk enter the history and do not alter the slice in progress.
- R11: A commit that has the candidate flag set but a kind other than 0 starts no detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cm_valid | input | 1 | A commit is present this cycle |
| cm_kind | input | 2 | 0 integer, 1 store, 2 branch, 3 floating point |
| cm_pc | input | PC_W | PC of the commit |
| cm_insn | input | IW | Instruction word of the commit |
| cm_dst | input | $clog2(NREG) | Destination register |
| cm_src_a | input | $clog2(NREG) | First source register |
| cm_src_b | input | $clog2(NREG) | Second source register |
| cm_cand | input | 1 | Commit is a frequently missing load |
| sl_valid | output | 1 | One-cycle slice write strobe |
| sl_lead_pc | output | PC_W | PC of the oldest slice member |
| sl_count | output | $clog2(MAXS+1) | Number of slice instructions |
| sl_trunc | output | 1 | Older members were dropped by the cap |
| sl_insns | output | MAXS*IW | Slice instruction words, oldest in slot 0 |
| busy | output | 1 | A detection walk is in progress |

## Verification
The bench builds the block with an 8-entry history and a 4-instruction cap, and keeps 32 registers and 32-bit words. The small history means a dozen commits are enough to exercise recycling of the oldest slot with column clearing. The small cap means a chain of seven self-dependent loads already produces truncation that keeps the youngest members. A long mixed stream over a handful of registers crosses both limits many times. During that stream, candidates arrive while a walk is still in progress and commits keep flowing, so the shadow copy is exercised together with the busy rejection.

// File: rtl/sds_pkg.sv
package sds_pkg;
  typedef enum logic [1:0] {
    K_INT    = 2'd0,
    K_STORE  = 2'd1,
    K_BRANCH = 2'd2,
    K_FLOAT  = 2'd3
  } kind_e;

  typedef enum logic {
    W_IDLE = 1'b0,
    W_WALK = 1'b1
  } walk_st_e;
endpackage

// File: rtl/sds_prod_table.sv
module sds_prod_table #(
  parameter int NREG  = 32,
  parameter int RW    = 5,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_en,
  input  logic [IDX_W-1:0] ev_idx,
  input  logic             wr_en,
  input  logic [RW-1:0]    wr_reg,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [RW-1:0]    rd_a,
  input  logic [RW-1:0]    rd_b,
  output logic             a_hit,
  output logic [IDX_W-1:0] a_idx,
  output logic             b_hit,
  output logic [IDX_W-1:0] b_idx
);
  logic [NREG-1:0]  vld_q, vld_d;
  logic [IDX_W-1:0] idx_q [NREG];
  logic [IDX_W-1:0] idx_d [NREG];

  // lookup sees the slot being recycled this cycle as already gone
  always_comb begin
    a_idx = idx_q[rd_a];
    b_idx = idx_q[rd_b];
    a_hit = (rd_a != '0) && vld_q[rd_a] && !(ev_en && (idx_q[rd_a] == ev_idx));
    b_hit = (rd_b != '0) && vld_q[rd_b] && !(ev_en && (idx_q[rd_b] == ev_idx));
  end

  always_comb begin
    for (int r = 0; r < NREG; r++) begin
      vld_d[r] = vld_q[r] && !(ev_en && (idx_q[r] == ev_idx));
      idx_d[r] = idx_q[r];
    end
    if (wr_en && (wr_reg != '0)) begin
      vld_d[wr_reg] = 1'b1;
      idx_d[wr_reg] = wr_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int r = 0; r < NREG; r++) idx_q[r] <= '0;
    end else begin
      vld_q <= vld_d;
      for (int r = 0; r < NREG; r++) idx_q[r] <= idx_d[r];
    end
  end
endmodule

// File: rtl/sds_work_buf.sv
module sds_work_buf #(
  parameter int DEPTH = 32,
  parameter int PC_W  = 32,
  parameter int IW    = 32,
  parameter int IDX_W = 5,
  parameter int OCC_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_en,
  input  logic [PC_W-1:0]  ins_pc,
  input  logic [IW-1:0]    ins_insn,
  input  logic [DEPTH-1:0] ins_dv,
  output logic [IDX_W-1:0] slot,
  output logic             ev_en,
  output logic [IDX_W-1:0] ev_idx,
  output logic [OCC_W-1:0] occ_q,
  output logic [OCC_W-1:0] occ_d,
  output logic [PC_W-1:0]  pc_d   [DEPTH],
  output logic [IW-1:0]    insn_d [DEPTH],
  output logic [DEPTH-1:0] dv_d   [DEPTH]
);
  logic [IDX_W-1:0] head_q, head_d, tail_q, tail_d;
  logic [PC_W-1:0]  pc_q   [DEPTH];
  logic [IW-1:0]    insn_q [DEPTH];
  logic [DEPTH-1:0] dv_q   [DEPTH];
  logic             full;
  logic [DEPTH-1:0] col_keep;

  function automatic logic [IDX_W-1:0] wrap_inc(input logic [IDX_W-1:0] x);
    return (x == IDX_W'(DEPTH - 1)) ? '0 : x + IDX_W'(1);
  endfunction

  always_comb begin
    full   = (occ_q == OCC_W'(DEPTH));
    slot   = tail_q;
    ev_en  = ins_en && full;
    ev_idx = head_q;
    head_d = head_q;
    tail_d = tail_q;
    occ_d  = occ_q;
    if (ins_en) begin
      tail_d = wrap_inc(tail_q);
      if (full) head_d = wrap_inc(head_q);
      else      occ_d  = occ_q + OCC_W'(1);
    end
  end

  // column reset of the recycled slot, then the new entry
  always_comb begin
    col_keep = '1;
    if (ev_en) col_keep[ev_idx] = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin
      pc_d[k]   = pc_q[k];
      insn_d[k] = insn_q[k];
      dv_d[k]   = dv_q[k] & col_keep;
    end
    if (ins_en) begin
      pc_d[slot]   = ins_pc;
      insn_d[slot] = ins_insn;
      dv_d[slot]   = ins_dv;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      occ_q  <= '0;
      for (int k = 0; k < DEPTH; k++) dv_q[k] <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      occ_q  <= occ_d;
      for (int k = 0; k < DEPTH; k++) dv_q[k] <= dv_d[k];
    end
  end

  always_ff @(posedge clk) begin
    if (ins_en) begin
      for (int k = 0; k < DEPTH; k++) begin
        pc_q[k]   <= pc_d[k];
        insn_q[k] <= insn_d[k];
      end
    end
  end
endmodule

// File: rtl/sds_walker.sv
module sds_walker
  import sds_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int PC_W   = 32,
  parameter int IW     = 32,
  parameter int MAXS   = 16,
  parameter int IDX_W  = 5,
  parameter int OCC_W  = 6,
  parameter int CNT_W  = 5,
  parameter int SLOT_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [IDX_W-1:0]   cand_idx,
  input  logic [OCC_W-1:0]   occ_in,
  input  logic [PC_W-1:0]    pc_in   [DEPTH],
  input  logic [IW-1:0]      insn_in [DEPTH],
  input  logic [DEPTH-1:0]   dv_in   [DEPTH],
  output logic               busy,
  output logic               out_valid,
  output logic [PC_W-1:0]    out_lead,
  output logic [CNT_W-1:0]   out_cnt,
  output logic               out_trunc,
  output logic [MAXS*IW-1:0] out_insns
);
  walk_st_e         st_q, st_d;
  logic [DEPTH-1:0] run_q, run_d;
  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic [OCC_W-1:0] rem_q, rem_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             trunc_q, trunc_d;
  logic [PC_W-1:0]  lead_q, lead_d;
  logic [IW-1:0]    coll_q [MAXS];
  logic [IW-1:0]    coll_d [MAXS];
  logic [PC_W-1:0]  sh_pc   [DEPTH];
  logic [IW-1:0]    sh_insn [DEPTH];
  logic [DEPTH-1:0] sh_dv   [DEPTH];
  logic             sh_load;
  logic             ov_d, ot_d;
  logic [PC_W-1:0]  ol_d;
  logic [CNT_W-1:0] oc_d;
  logic [MAXS*IW-1:0] rev;
  logic             emit;

  function automatic logic [IDX_W-1:0] wrap_dec(input logic [IDX_W-1:0] x);
    return (x == '0) ? IDX_W'(DEPTH - 1) : x - IDX_W'(1);
  endfunction

  assign busy = (st_q == W_WALK);

  // members were gathered youngest first; turn them to oldest first
  always_comb begin
    rev = '0;
    for (int j = 0; j < MAXS; j++) begin
      logic [SLOT_W-1:0] src;
      src = SLOT_W'(int'(cnt_q) - 1 - j);
      if (CNT_W'(j) < cnt_q) rev[j*IW +: IW] = coll_q[src];
    end
  end

  always_comb begin
    st_d    = st_q;
    run_d   = run_q;
    ptr_d   = ptr_q;
    rem_d   = rem_q;
    cnt_d   = cnt_q;
    trunc_d = trunc_q;
    lead_d  = lead_q;
    coll_d  = coll_q;
    sh_load = 1'b0;
    emit    = 1'b0;
    case (st_q)
      W_IDLE: begin
        if (start) begin
          sh_load = 1'b1;
          st_d    = W_WALK;
          run_d   = dv_in[cand_idx];
          ptr_d   = wrap_dec(cand_idx);
          rem_d   = occ_in - OCC_W'(1);
          cnt_d   = CNT_W'(1);
          trunc_d = 1'b0;
          lead_d  = pc_in[cand_idx];
          for (int j = 0; j < MAXS; j++) coll_d[j] = '0;
          coll_d[0] = insn_in[cand_idx];
        end
      end
      default: begin
        if (rem_q == '0) begin
          emit = 1'b1;
          st_d = W_IDLE;
        end else begin
          if (run_q[ptr_q]) begin
            run_d = run_q | sh_dv[ptr_q];
            if (cnt_q < CNT_W'(MAXS)) begin
              coll_d[cnt_q[SLOT_W-1:0]] = sh_insn[ptr_q];
              cnt_d  = cnt_q + CNT_W'(1);
              lead_d = sh_pc[ptr_q];
            end else begin
              trunc_d = 1'b1;
            end
          end
          ptr_d = wrap_dec(ptr_q);
          rem_d = rem_q - OCC_W'(1);
        end
      end
    endcase
    ov_d = emit;
    ol_d = lead_q;
    oc_d = cnt_q;
    ot_d = trunc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= W_IDLE;
      run_q     <= '0;
      ptr_q     <= '0;
      rem_q     <= '0;
      cnt_q     <= '0;
      trunc_q   <= 1'b0;
      lead_q    <= '0;
      out_valid <= 1'b0;
      out_lead  <= '0;
      out_cnt   <= '0;
      out_trunc <= 1'b0;
      out_insns <= '0;
    end else begin
      st_q      <= st_d;
      run_q     <= run_d;
      ptr_q     <= ptr_d;
      rem_q     <= rem_d;
      cnt_q     <= cnt_d;
      trunc_q   <= trunc_d;
      lead_q    <= lead_d;
      out_valid <= ov_d;
      if (emit) begin
        out_lead  <= ol_d;
        out_cnt   <= oc_d;
        out_trunc <= ot_d;
        out_insns <= rev;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int j = 0; j < MAXS; j++) coll_q[j] <= coll_d[j];
    if (sh_load) begin
      for (int k = 0; k < DEPTH; k++) begin
        sh_pc[k]   <= pc_in[k];
        sh_insn[k] <= insn_in[k];
        sh_dv[k]   <= dv_in[k];
      end
    end
  end
endmodule

// File: rtl/sds_slice_detector.sv
module sds_slice_detector
  import sds_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int NREG  = 32,
  parameter int PC_W  = 32,
  parameter int IW    = 32,
  parameter int MAXS  = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cm_valid,
  input  logic [1:0]                 cm_kind,
  input  logic [PC_W-1:0]            cm_pc,
  input  logic [IW-1:0]              cm_insn,
  input  logic [$clog2(NREG)-1:0]    cm_dst,
  input  logic [$clog2(NREG)-1:0]    cm_src_a,
  input  logic [$clog2(NREG)-1:0]    cm_src_b,
  input  logic                       cm_cand,
  output logic                       sl_valid,
  output logic [PC_W-1:0]            sl_lead_pc,
  output logic [$clog2(MAXS+1)-1:0]  sl_count,
  output logic                       sl_trunc,
  output logic [MAXS*IW-1:0]         sl_insns,
  output logic                       busy
);
  localparam int RW     = $clog2(NREG);
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OCC_W  = $clog2(DEPTH + 1);
  localparam int CNT_W  = $clog2(MAXS + 1);
  localparam int SLOT_W = (MAXS > 1) ? $clog2(MAXS) : 1;

  logic             ins_en, start;
  logic             a_hit, b_hit, ev_en;
  logic [IDX_W-1:0] a_idx, b_idx, ev_idx, slot;
  logic [DEPTH-1:0] dv_new;
  logic [OCC_W-1:0] occ_q, occ_d;
  logic [PC_W-1:0]  pc_d   [DEPTH];
  logic [IW-1:0]    insn_d [DEPTH];
  logic [DEPTH-1:0] dv_d   [DEPTH];

  always_comb begin
    ins_en = cm_valid && (kind_e'(cm_kind) == K_INT);
    start  = ins_en && cm_cand && !busy;
    dv_new = '0;
    if (a_hit) dv_new[a_idx] = 1'b1;
    if (b_hit) dv_new[b_idx] = 1'b1;
  end

  sds_prod_table #(.NREG(NREG), .RW(RW), .IDX_W(IDX_W)) u_pt (
    .clk    (clk),
    .rst_n  (rst_n),
    .ev_en  (ev_en),
    .ev_idx (ev_idx),
    .wr_en  (ins_en),
    .wr_reg (cm_dst),
    .wr_idx (slot),
    .rd_a   (cm_src_a),
    .rd_b   (cm_src_b),
    .a_hit  (a_hit),
    .a_idx  (a_idx),
    .b_hit  (b_hit),
    .b_idx  (b_idx)
  );

  sds_work_buf #(
    .DEPTH(DEPTH), .PC_W(PC_W), .IW(IW), .IDX_W(IDX_W), .OCC_W(OCC_W)
  ) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .ins_en   (ins_en),
    .ins_pc   (cm_pc),
    .ins_insn (cm_insn),
    .ins_dv   (dv_new),
    .slot     (slot),
    .ev_en    (ev_en),
    .ev_idx   (ev_idx),
    .occ_q    (occ_q),
    .occ_d    (occ_d),
    .pc_d     (pc_d),
    .insn_d   (insn_d),
    .dv_d     (dv_d)
  );

  sds_walker #(
    .DEPTH(DEPTH), .PC_W(PC_W), .IW(IW), .MAXS(MAXS),
    .IDX_W(IDX_W), .OCC_W(OCC_W), .CNT_W(CNT_W), .SLOT_W(SLOT_W)
  ) u_walk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cand_idx  (slot),
    .occ_in    (occ_d),
    .pc_in     (pc_d),
    .insn_in   (insn_d),
    .dv_in     (dv_d),
    .busy      (busy),
    .out_valid (sl_valid),
    .out_lead  (sl_lead_pc),
    .out_cnt   (sl_count),
    .out_trunc (sl_trunc),
    .out_insns (sl_insns)
  );
endmodule

// File: rtl/sds_checker.sv
module sds_checker #(
  parameter int DEPTH = 32,
  parameter int MAXS  = 16
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      sl_valid,
  input logic [$clog2(MAXS+1)-1:0] sl_count,
  input logic                      sl_trunc,
  input logic                      busy,
  input logic                      cm_valid,
  input logic [1:0]                cm_kind,
  input logic                      cm_cand,
  input logic [$clog2(DEPTH+1)-1:0] occ
);
  logic [31:0] walk_cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) walk_cyc <= '0;
    else        walk_cyc <= busy ? walk_cyc + 32'd1 : '0;
  end

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sl_valid |=> !sl_valid);

  a_r9_idle_at_emit: assert property (@(posedge clk) disable iff (!rst_n)
    sl_valid |-> !busy);

  a_r9_end_has_emit: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> sl_valid);

  a_r9_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_valid && (cm_kind == 2'd0) && cm_cand && !busy) |=> busy);

  a_r11_other_kind_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(cm_valid && (cm_kind == 2'd0) && cm_cand)) |=> !busy);

  a_r9_walk_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (walk_cyc < 32'(DEPTH)));

  a_r8_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    sl_valid |-> ((sl_count != '0) && (32'(sl_count) <= 32'(MAXS))));

  a_r8_trunc_at_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (sl_valid && sl_trunc) |-> (32'(sl_count) == 32'(MAXS)));

  a_r4_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
    32'(occ) <= 32'(DEPTH));
endmodule

bind sds_slice_detector sds_checker #(.DEPTH(DEPTH), .MAXS(MAXS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sl_valid (sl_valid),
  .sl_count (sl_count),
  .sl_trunc (sl_trunc),
  .busy     (busy),
  .cm_valid (cm_valid),
  .cm_kind  (cm_kind),
  .cm_cand  (cm_cand),
  .occ      (occ_q)
);

// File: tb/sim_sds_slice_detector.sv
module sim_sds_slice_detector;
  localparam int DEPTH = 8;
  localparam int NREG  = 32;
  localparam int PC_W  = 32;
  localparam int IW    = 32;
  localparam int MAXS  = 4;
  localparam int RW    = $clog2(NREG);
  localparam int CNT_W = $clog2(MAXS + 1);

  logic               clk, rst_n;
  logic               cm_valid, cm_cand;
  logic [1:0]         cm_kind;
  logic [PC_W-1:0]    cm_pc;
  logic [IW-1:0]      cm_insn;
  logic [RW-1:0]      cm_dst, cm_src_a, cm_src_b;
  logic               sl_valid, sl_trunc, busy;
  logic [PC_W-1:0]    sl_lead_pc;
  logic [CNT_W-1:0]   sl_count;
  logic [MAXS*IW-1:0] sl_insns;

  sds_slice_detector #(.DEPTH(DEPTH), .NREG(NREG), .PC_W(PC_W), .IW(IW), .MAXS(MAXS)) u0 (
    .clk(clk), .rst_n(rst_n), .cm_valid(cm_valid), .cm_kind(cm_kind), .cm_pc(cm_pc),
    .cm_insn(cm_insn), .cm_dst(cm_dst), .cm_src_a(cm_src_a), .cm_src_b(cm_src_b),
    .cm_cand(cm_cand), .sl_valid(sl_valid), .sl_lead_pc(sl_lead_pc), .sl_count(sl_count),
    .sl_trunc(sl_trunc), .sl_insns(sl_insns), .busy(busy)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct {
    logic [31:0] pc;
    logic [31:0] insn;
    int          dst, sa, sb;
  } rec_t;

  typedef struct {
    logic [31:0] lead;
    int          cnt;
    bit          trunc;
    logic [31:0] ins [MAXS];
    longint      cyc;
    string       tag;
  } exp_t;

  rec_t   hist[$];
  exp_t   sbq[$];
  int     n_chk = 0;
  int     n_fail = 0;
  longint cyc = 0;
  bit     done = 0;
  logic [31:0] pc_ctr = 32'h1000;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string msg);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s", msg);
    end
  endtask

  // reference slice from register dataflow over the last DEPTH recorded commits
  function automatic exp_t model(input string tag, input longint c);
    exp_t        e;
    logic [31:0] tmp [MAXS];
    bit [31:0]   need;
    rec_t        r;
    int          n;
    n = hist.size();
    r = hist[n-1];
    need = '0;
    if (r.sa != 0) need[r.sa] = 1'b1;
    if (r.sb != 0) need[r.sb] = 1'b1;
    e.cnt = 1; e.trunc = 0; e.lead = r.pc; tmp[0] = r.insn;
    for (int i = n - 2; i >= 0; i--) begin
      if (hist[i].dst != 0 && need[hist[i].dst]) begin
        need[hist[i].dst] = 1'b0;
        if (hist[i].sa != 0) need[hist[i].sa] = 1'b1;
        if (hist[i].sb != 0) need[hist[i].sb] = 1'b1;
        if (e.cnt < MAXS) begin
          tmp[e.cnt] = hist[i].insn;
          e.lead = hist[i].pc;
          e.cnt++;
        end else begin
          e.trunc = 1;
        end
      end
    end
    for (int j = 0; j < MAXS; j++) e.ins[j] = (j < e.cnt) ? tmp[e.cnt-1-j] : 32'h0;
    e.cyc = c + 1 + n;
    e.tag = tag;
    return e;
  endfunction

  task automatic send(input logic [1:0] kind, input int dst, input int sa, input int sb,
                      input bit cand, input string tag);
    rec_t r;
    bit   bsy;
    @(negedge clk);
    bsy = busy;
    pc_ctr = pc_ctr + 32'd4;
    r.pc = pc_ctr; r.insn = $urandom; r.dst = dst; r.sa = sa; r.sb = sb;
    cm_valid = 1'b1; cm_kind = kind; cm_pc = r.pc; cm_insn = r.insn;
    cm_dst = RW'(dst); cm_src_a = RW'(sa); cm_src_b = RW'(sb); cm_cand = cand;
    if (kind == 2'd0) begin
      hist.push_back(r);
      if (hist.size() > DEPTH) void'(hist.pop_front());
      if (cand && !bsy) sbq.push_back(model(tag, cyc));
    end
  endtask

  task automatic idle();
    @(negedge clk);
    cm_valid = 1'b0; cm_cand = 1'b0;
  endtask

  task automatic drain();
    idle();
    while (sbq.size() != 0 || busy) @(negedge clk);
    @(negedge clk);
  endtask

  always @(negedge clk) begin : mon
    exp_t        e;
    bit          ok;
    logic [MAXS*IW-1:0] ef;
    if (rst_n && sl_valid) begin
      if (sbq.size() == 0) begin
        check(1'b0, $sformatf("R10 unexpected slice lead %h count %0d, expected none", sl_lead_pc, sl_count));
      end else begin
        e = sbq.pop_front();
        ef = '0;
        for (int j = 0; j < MAXS; j++) ef[j*IW +: IW] = e.ins[j];
        ok = (sl_lead_pc == e.lead) && (int'(sl_count) == e.cnt) && (sl_trunc == e.trunc) &&
             (cyc == e.cyc) && (sl_insns == ef);
        check(ok, $sformatf("%s: lead %h/%h count %0d/%0d trunc %0d/%0d cycle %0d/%0d slots %h/%h (actual/expected)",
              e.tag, sl_lead_pc, e.lead, sl_count, e.cnt, sl_trunc, e.trunc, cyc, e.cyc, sl_insns, ef));
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired, pending slices %0d", sbq.size());
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    cm_valid = 0; cm_cand = 0; cm_kind = 0; cm_pc = 0; cm_insn = 0;
    cm_dst = 0; cm_src_a = 0; cm_src_b = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    check(!sl_valid && !busy, $sformatf("R1 in reset valid %0d busy %0d, expected 0 0", sl_valid, busy));
    rst_n = 1;
    repeat (2) @(negedge clk);
    check(!sl_valid && !busy, $sformatf("R1 after reset valid %0d busy %0d, expected 0 0", sl_valid, busy));

    // linked-list walk with a store and a branch that must not be recorded
    send(2'd0, 1, 1, 0, 0, "");
    send(2'd0, 2, 1, 0, 0, "");
    send(2'd1, 1, 2, 1, 0, "");
    send(2'd0, 1, 1, 0, 0, "");
    send(2'd2, 1, 1, 0, 0, "");
    send(2'd0, 3, 2, 3, 0, "");
    send(2'd0, 1, 1, 0, 1, "R2 R5 R6 R7 R9 list");
    idle();
    check(busy, $sformatf("R9 busy after accept %0d, expected 1", busy));
    drain();

    // producer of r5 pushed out of the history
    send(2'd0, 5, 0, 0, 0, "");
    for (int i = 0; i < DEPTH; i++) send(2'd0, 6, 6, 0, 0, "");
    send(2'd0, 7, 5, 0, 1, "R4 evicted producer");
    drain();

    // chain longer than the cap
    for (int i = 0; i < 6; i++) send(2'd0, 4, 4, 0, 0, "");
    send(2'd0, 4, 4, 0, 1, "R8 truncation");
    drain();

    // register 0 is no producer
    send(2'd0, 0, 3, 0, 0, "");
    send(2'd0, 10, 0, 0, 1, "R3 r0 source");
    drain();
    send(2'd0, 9, 9, 0, 0, "");
    send(2'd0, 9, 0, 9, 0, "");
    send(2'd0, 11, 9, 9, 1, "R3 most recent producer");
    drain();

    // candidate flag on other kinds
    send(2'd1, 0, 4, 4, 1, "");
    idle();
    check(!busy, $sformatf("R11 store candidate busy %0d, expected 0", busy));
    send(2'd3, 4, 4, 0, 1, "");
    idle();
    check(!busy, $sformatf("R11 float candidate busy %0d, expected 0", busy));
    drain();

    // candidate during a walk, commits during a walk
    send(2'd0, 11, 4, 0, 1, "R10 first");
    send(2'd0, 12, 11, 0, 1, "R10 ignored");
    send(2'd0, 13, 12, 0, 0, "");
    idle();
    check(busy, $sformatf("R10 walk still busy %0d, expected 1", busy));
    drain();
    send(2'd0, 14, 13, 0, 1, "R10 after walk");
    drain();

    // mixed stream
    for (int i = 0; i < 3000; i++) begin
      int k;
      k = $urandom % 10;
      send((k < 7) ? 2'd0 : 2'($urandom % 4), $urandom % 8, $urandom % 8, $urandom % 8,
           ($urandom % 6) == 0, "R2 R3 R4 R5 R6 R7 R8 R9 R10 random");
    end
    drain();
    check(sbq.size() == 0, $sformatf("R9 pending slices %0d, expected 0", sbq.size()));

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule